// File: doc/BRIEF.md
# Tiled texture address generator

This block turns a texel coordinate into a byte address for a texture stored in a two-level square-blocked layout. Texels are 32 bits wide. A 128-bit memory word holds a 2x2 group of texels, and a 4 KB page holds a 32x32 group. Both levels come from interleaving the low coordinate bits, with x on the even positions and y on the odd positions. Because of this, a walk along a row and a walk down a column both stay inside one page for 32 texels. A plain raster layout would leave the page after only a few texels when walking down a column.

Pages are placed in row-major order across the texture. The caller supplies the page number where the texture starts and the base-2 log of the texture width. The width must be a power of two and at least 32. The block is fully pipelined and accepts one coordinate on every clock with no stall. Each result shows up two clock edges after its coordinate, as three fields: the full byte address, the page index inside the texture, and the byte offset inside the page.

Top module: `tex_tile_addr`

## Requirements
- R1: `o_valid` equals `i_valid` as sampled two rising edges earlier. While `rst` is high and on the first edge after it, `o_valid` is 0.
- R2: The in-page texel index is a 10-bit value. Bit 2k holds x[k] and bit 2k+1 holds y[k], for k = 0..4. `o_offset` equals that index times 4.
- R3: The four texels with x = 2a or 2a+1 and y = 2b or 2b+1 give the same `o_addr[31:4]`, which is one 128-bit word. Their `o_addr[3:0]` values are 0, 4, 8 and 12 for (x[0],y[0]) = (0,0), (1,0), (0,1) and (1,1).
- R4: With width W = 2^L, `o_page` = floor(y/32) * (W/32) + floor(x/32). All coordinates inside one aligned 32x32 square give the same `o_page`.
- R5: `o_addr[31:12]` equals `i_base_pg + o_page` modulo 2^20, and `o_addr[11:0]` equals `o_offset`.
- R6: An `i_wlg` value below 5 is treated as 5. A value above 12 is treated as 12.
- R7: Bits of x at or above the effective width log are ignored, so x is taken modulo W.
- R8: A new coordinate can be accepted on every cycle. Each result depends only on the inputs sampled on its own cycle, including when valid and idle cycles alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Coordinate present this cycle |
| i_x | input | 12 | Texel column |
| i_y | input | 12 | Texel row |
| i_base_pg | input | 20 | 4 KB page number where the texture starts |
| i_wlg | input | 4 | Base-2 log of texture width in texels |
| o_valid | output | 1 | Result valid |
| o_addr | output | 32 | Byte address of the texel |
| o_page | output | 14 | Page index within the texture |
| o_offset | output | 12 | Byte offset within the page |

## Verification
The bound checker checks four things on every cycle:
- The two-edge valid latency, in both directions.
- The 4-byte alignment of the offset.
- The split of the address into its page part and its offset part.
- The sum of the base page and the page index, compared with the base sampled two cycles earlier.

Other behaviours can only be shown by the bench's scenarios, using its reference model:
- The bit interleave that forms each word and each page.
- The row-major page order for each width.
- The clamping of out-of-range width logs.
- The wrapping of x modulo the width.
- Correct results under back-to-back streams and bubble streams.

// File: rtl/tex_tile_pkg.sv
package tex_tile_pkg;
  // log2 of the page side in texels (32x32 texels per page)
  localparam int TILE_LG  = 5;
  // log2 of bytes per texel (32-bit texels)
  localparam int TEXEL_LG = 2;
  // byte offset width inside a page: 2*5 index bits + 2 byte bits = 4 KB
  localparam int OFFS_W   = 2 * TILE_LG + TEXEL_LG;
endpackage

// File: rtl/tile_in_stage.sv
// Input register stage.
// Clamps the width log into the legal range and wraps x modulo the width.
module tile_in_stage
  import tex_tile_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int PG_W    = 20,
  parameter int WLG_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               i_valid,
  input  logic [COORD_W-1:0] i_x,
  input  logic [COORD_W-1:0] i_y,
  input  logic [PG_W-1:0]    i_base_pg,
  input  logic [WLG_W-1:0]   i_wlg,
  output logic               s_valid,
  output logic [COORD_W-1:0] s_x,
  output logic [COORD_W-1:0] s_y,
  output logic [PG_W-1:0]    s_base_pg,
  output logic [WLG_W-1:0]   s_cols_lg
);
  logic [WLG_W-1:0]   wlg_eff;
  logic [COORD_W-1:0] x_keep;

  // R6: clamp the width log to [TILE_LG, COORD_W]
  always_comb begin
    if (i_wlg < WLG_W'(TILE_LG))
      wlg_eff = WLG_W'(TILE_LG);
    else if (i_wlg > WLG_W'(COORD_W))
      wlg_eff = WLG_W'(COORD_W);
    else
      wlg_eff = i_wlg;
  end

  // R7: keep only x bits below the effective width log
  for (genvar g = 0; g < COORD_W; g++) begin : g_xmask
    assign x_keep[g] = (g < int'(wlg_eff));
  end

  always_ff @(posedge clk) begin
    if (rst) s_valid <= 1'b0;
    else     s_valid <= i_valid;
  end

  always_ff @(posedge clk) begin
    s_x       <= i_x & x_keep;
    s_y       <= i_y;
    s_base_pg <= i_base_pg;
    s_cols_lg <= wlg_eff - WLG_W'(TILE_LG);
  end
endmodule

// File: rtl/tile_swizzle.sv
// Interleaves the in-page coordinate bits: x on even positions, y on odd positions.
module tile_swizzle #(
  parameter int SIDE_LG = 5
) (
  input  logic [SIDE_LG-1:0]   tx,
  input  logic [SIDE_LG-1:0]   ty,
  output logic [2*SIDE_LG-1:0] idx
);
  for (genvar g = 0; g < SIDE_LG; g++) begin : g_lace
    assign idx[2*g]   = tx[g];
    assign idx[2*g+1] = ty[g];
  end
endmodule

// File: rtl/tile_page_index.sv
// Row-major page index: page_row * pages_per_row + page_col.
module tile_page_index #(
  parameter int PT_W  = 7,
  parameter int WLG_W = 4
) (
  input  logic [PT_W-1:0]   px,
  input  logic [PT_W-1:0]   py,
  input  logic [WLG_W-1:0]  cols_lg,
  output logic [2*PT_W-1:0] pidx
);
  logic [2*PT_W-1:0] row_start;

  always_comb begin
    row_start = {{PT_W{1'b0}}, py} << cols_lg;
    pidx      = row_start + {{PT_W{1'b0}}, px};
  end
endmodule

// File: rtl/tex_tile_addr.sv
// Top level: register stage, swizzle, page index, then registered outputs.
module tex_tile_addr
  import tex_tile_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 32,
  parameter int WLG_W   = 4,
  localparam int PG_W   = ADDR_W - OFFS_W,
  localparam int PT_W   = COORD_W - TILE_LG,
  localparam int PIDX_W = 2 * PT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               i_valid,
  input  logic [COORD_W-1:0] i_x,
  input  logic [COORD_W-1:0] i_y,
  input  logic [PG_W-1:0]    i_base_pg,
  input  logic [WLG_W-1:0]   i_wlg,
  output logic               o_valid,
  output logic [ADDR_W-1:0]  o_addr,
  output logic [PIDX_W-1:0]  o_page,
  output logic [OFFS_W-1:0]  o_offset
);
  logic               s_valid;
  logic [COORD_W-1:0] s_x;
  logic [COORD_W-1:0] s_y;
  logic [PG_W-1:0]    s_base_pg;
  logic [WLG_W-1:0]   s_cols_lg;
  logic [2*TILE_LG-1:0] texel_idx;
  logic [PIDX_W-1:0]  pidx;
  logic [OFFS_W-1:0]  offs;
  logic [PG_W-1:0]    addr_pg;

  tile_in_stage #(
    .COORD_W (COORD_W),
    .PG_W    (PG_W),
    .WLG_W   (WLG_W)
  ) u_in (
    .clk       (clk),
    .rst       (rst),
    .i_valid   (i_valid),
    .i_x       (i_x),
    .i_y       (i_y),
    .i_base_pg (i_base_pg),
    .i_wlg     (i_wlg),
    .s_valid   (s_valid),
    .s_x       (s_x),
    .s_y       (s_y),
    .s_base_pg (s_base_pg),
    .s_cols_lg (s_cols_lg)
  );

  tile_swizzle #(
    .SIDE_LG (TILE_LG)
  ) u_swz (
    .tx  (s_x[TILE_LG-1:0]),
    .ty  (s_y[TILE_LG-1:0]),
    .idx (texel_idx)
  );

  tile_page_index #(
    .PT_W  (PT_W),
    .WLG_W (WLG_W)
  ) u_pg (
    .px      (s_x[COORD_W-1:TILE_LG]),
    .py      (s_y[COORD_W-1:TILE_LG]),
    .cols_lg (s_cols_lg),
    .pidx    (pidx)
  );

  always_comb begin
    offs    = {texel_idx, {TEXEL_LG{1'b0}}};
    addr_pg = s_base_pg + PG_W'(pidx);
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else     o_valid <= s_valid;
  end

  always_ff @(posedge clk) begin
    o_addr   <= {addr_pg, offs};
    o_page   <= pidx;
    o_offset <= offs;
  end
endmodule

// File: rtl/tex_tile_addr_chk.sv
module tex_tile_addr_chk
  import tex_tile_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PIDX_W = 14,
  localparam int PG_W  = ADDR_W - OFFS_W
) (
  input logic              clk,
  input logic              rst,
  input logic              i_valid,
  input logic [PG_W-1:0]   i_base_pg,
  input logic              o_valid,
  input logic [ADDR_W-1:0] o_addr,
  input logic [PIDX_W-1:0] o_page,
  input logic [OFFS_W-1:0] o_offset
);
  // R1: an accepted coordinate yields a result two edges later
  a_r1_valid_lat: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> ##1 o_valid);

  // R1: an idle cycle yields no result two edges later
  a_r1_idle_lat: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> ##1 !o_valid);

  // R2: the offset addresses whole 32-bit texels
  a_r2_offset_aligned: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_offset[TEXEL_LG-1:0] == '0));

  // R5: the low address bits carry the in-page offset
  a_r5_addr_low: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_addr[OFFS_W-1:0] == o_offset));

  // R5: the high address bits are the base page plus the page index
  a_r5_addr_page: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_addr[ADDR_W-1:OFFS_W] == PG_W'($past(i_base_pg, 2) + PG_W'(o_page))));
endmodule

bind tex_tile_addr tex_tile_addr_chk #(
  .ADDR_W (ADDR_W),
  .PIDX_W (PIDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .i_valid   (i_valid),
  .i_base_pg (i_base_pg),
  .o_valid   (o_valid),
  .o_addr    (o_addr),
  .o_page    (o_page),
  .o_offset  (o_offset)
);

// File: tb/sim_tex_tile_addr.sv
module sim_tex_tile_addr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_valid = 1'b0;
  logic [11:0] i_x = '0;
  logic [11:0] i_y = '0;
  logic [19:0] i_base_pg = '0;
  logic [3:0]  i_wlg = 4'd5;
  logic        o_valid;
  logic [31:0] o_addr;
  logic [13:0] o_page;
  logic [11:0] o_offset;

  always #4 clk = ~clk;  // 125 MHz

  tex_tile_addr u0 (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_x(i_x), .i_y(i_y),
    .i_base_pg(i_base_pg), .i_wlg(i_wlg), .o_valid(o_valid),
    .o_addr(o_addr), .o_page(o_page), .o_offset(o_offset)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit      qv[$];
  longint  qa[$];
  longint  qp[$];
  longint  qo[$];
  string   qt[$];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  task automatic push_model(bit v, int x, int y, longint bpg, int wlg, string tag);
    int wc, w, xm, idx, pg, off;
    wc = (wlg < 5) ? 5 : ((wlg > 12) ? 12 : wlg);
    w  = 1 << wc;
    xm = x % w;
    pg = (y / 32) * (w / 32) + xm / 32;
    idx = 0;
    for (int b = 0; b < 5; b++)
      idx += (((xm >> b) & 1) << (2 * b)) + (((y >> b) & 1) << (2 * b + 1));
    off = idx * 4;
    qv.push_back(v);
    qa.push_back((((bpg + pg) % (64'd1 << 20)) << 12) + off);
    qp.push_back(pg);
    qo.push_back(off);
    qt.push_back(tag);
  endtask

  task automatic compare_front();
    bit v; longint a, p, o; string t;
    v = qv.pop_front(); a = qa.pop_front(); p = qp.pop_front();
    o = qo.pop_front(); t = qt.pop_front();
    chk(v ? t : "R1", "valid", 64'(o_valid), 64'(v));
    if (v) begin
      chk(t, "addr",   64'(o_addr),   64'(a));
      chk(t, "page",   64'(o_page),   64'(p));
      chk(t, "offset", 64'(o_offset), 64'(o));
    end
  endtask

  task automatic drive(bit v, int x, int y, longint bpg, int wlg, string tag);
    @(negedge clk);
    if (qv.size() >= 2) compare_front();
    i_valid   = v;
    i_x       = 12'(x);
    i_y       = 12'(y);
    i_base_pg = 20'(bpg);
    i_wlg     = 4'(wlg);
    push_model(v, x, y, bpg, wlg, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 64'(o_valid), 64'd0);
    i_valid = 1'b1;  // R1: ignored while reset is held
    repeat (2) @(negedge clk);
    chk("R1", "valid under reset with input", 64'(o_valid), 64'd0);
    i_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid first edge after reset", 64'(o_valid), 64'd0);

    // R3: one 2x2 word group
    drive(1, 6, 10, 20'h00010, 8, "R3");
    drive(1, 7, 10, 20'h00010, 8, "R3");
    drive(1, 6, 11, 20'h00010, 8, "R3");
    drive(1, 7, 11, 20'h00010, 8, "R3");
    // R2: interleave corners
    drive(1, 31, 31, 20'h00010, 8, "R2");
    drive(1, 5, 10, 20'h00010, 8, "R2");
    drive(1, 21, 0, 20'h00010, 8, "R2");
    // R4: row and column walks cross page boundaries
    for (int x = 0; x < 100; x += 7) drive(1, x, 3, 20'h00200, 9, "R4");
    for (int y = 0; y < 100; y += 9) drive(1, 40, y, 20'h00200, 9, "R4");
    drive(1, 4000, 100, 20'h00300, 12, "R4");
    drive(1, 4095, 4095, 20'h00300, 12, "R4");
    // R5: base page and wrap of the page sum
    drive(1, 33, 65, 20'h12345, 7, "R5");
    drive(1, 4095, 4095, 20'hFFFFF, 12, "R5");
    // R6: width log clamping
    drive(1, 40, 70, 20'h00001, 0, "R6");
    drive(1, 40, 70, 20'h00001, 3, "R6");
    drive(1, 3000, 700, 20'h00001, 13, "R6");
    drive(1, 3000, 700, 20'h00001, 15, "R6");
    // R7: x at or beyond the width wraps
    drive(1, 70, 40, 20'h00002, 6, "R7");
    drive(1, 4095, 40, 20'h00002, 6, "R7");
    drive(1, 300, 5, 20'h00002, 8, "R7");
    // R8: back-to-back random stream
    for (int i = 0; i < 60; i++)
      drive(1, int'($urandom_range(4095)), int'($urandom_range(4095)),
            longint'($urandom_range(20'hFFFFF)), int'($urandom_range(15)), "R8");
    // R8: bubbles with changing idle inputs
    for (int i = 0; i < 40; i++)
      drive(i % 2 == 0, int'($urandom_range(4095)), int'($urandom_range(4095)),
            longint'($urandom_range(20'hFFFFF)), int'($urandom_range(15)), "R8");
    drive(0, 0, 0, 0, 5, "R1");
    drive(0, 0, 0, 0, 5, "R1");
    drive(0, 0, 0, 0, 5, "R1");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule